// File: doc/BRIEF.md
# Age-Priority Result Bus Arbiter

This block decides, cycle by cycle, which finished instruction in an out-of-order core may drive the single shared result broadcast bus. It also decides which waiting instruction may start on each non-pipelined execution unit. Each requester carries a wrap-around sequence number that gives its program-order age. In every contest the oldest eligible requester wins, and the losers hold their requests until they are served.

Finish requests carry a kind code. Floating-point and integer results compete for the bus. Branch and store completions never use the bus: they are acknowledged in the same cycle and only free their unit.

A unit is busy from the cycle after its start grant until the cycle after its occupant's finish is acknowledged. In that cycle a stalled instruction may start on it. The block keeps a registered copy of each broadcast. A start request that waits on a tag becomes eligible only in the cycle after that tag appears on the bus.

Top module: `rbus_age_arbiter`

## Requirements
- R1: At most one bit of `fin_gnt` is set in any cycle. `bus_valid` is high exactly when a bit is set, and `bus_tag`/`bus_data` then equal the granted requester's tag and data.
- R2: Among valid finish requests of a result kind, the oldest requester gets the bus. With SEQ_W-bit ages, age a is older than age b when bit SEQ_W-1 of (a - b) mod 2^SEQ_W is set; equal ages go to the lower index.
- R3: Kind codes per requester are 2'b00 floating-point, 2'b01 integer, 2'b10 branch and 2'b11 store. Branch and store requests never receive `fin_gnt` and never drive the bus; their `fin_ack` is set in the cycle they are presented.
- R4: For result kinds, `fin_ack` equals `fin_gnt`. A requester that is not granted gets no acknowledgement and is served in a later cycle while it keeps requesting.
- R5: A unit grants at most one start per cycle (`ex_gnt`), and only while its `unit_busy` bit is clear. It grants the oldest eligible requester naming that unit, using the R2 age rule. Different units may grant in the same cycle.
- R6: `unit_busy[u]` rises in the cycle after a start grant on unit u. It clears in the cycle after a `fin_ack` whose `fin_unit` is u, and a stalled start on u can be granted in that same cycle.
- R7: A start request with `ex_wait` set is eligible only if, in the previous cycle, `bus_valid` was high with `bus_tag` equal to its `ex_src_tag`. A matching broadcast in the current cycle does not make it eligible.
- R8: While `rst` is high, no grant, acknowledgement or broadcast is issued. After a reset cycle all units are free and the stored broadcast copy is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fin_valid | input | NREQ | Finish request per requester |
| fin_kind | input | NREQ*2 | Kind code per requester |
| fin_age | input | NREQ*SEQ_W | Program-order sequence number per finish request |
| fin_unit | input | NREQ*UIDX_W | Unit the finishing instruction occupies |
| fin_tag | input | NREQ*TAG_W | Destination tag to broadcast |
| fin_data | input | NREQ*DATA_W | Result value to broadcast |
| fin_gnt | output | NREQ | One-hot bus grant |
| fin_ack | output | NREQ | Finish accepted (bus grant or bus-free completion) |
| bus_valid | output | 1 | Broadcast valid this cycle |
| bus_tag | output | TAG_W | Broadcast destination tag |
| bus_data | output | DATA_W | Broadcast result value |
| ex_valid | input | NREQ | Start request per requester |
| ex_age | input | NREQ*SEQ_W | Program-order sequence number per start request |
| ex_unit | input | NREQ*UIDX_W | Unit requested |
| ex_wait | input | NREQ | Start request still waits on a source tag |
| ex_src_tag | input | NREQ*TAG_W | Tag being waited on |
| ex_gnt | output | NREQ | Start grants |
| unit_busy | output | NUNIT | Unit occupied |

## Verification
The hardest situation to reach from the ports is the one-cycle handoff on a non-pipelined unit. An occupant must finish in the same cycle that an older-blocked start request is waiting, and the start must appear exactly one cycle later. The bench first drives two start requests at the same unit so that one is refused. It holds that request while the occupant's finish is granted, then checks the refusal in the finish cycle and the grant in the next one. The tag-wakeup handoff is reached the same way. A waiting start request is held while a wrong tag is broadcast and then the right tag. The bench checks that the request stays blocked in the broadcast cycle and is granted only in the following one. Wrap-around ages are exercised with sequence numbers that straddle zero.

// File: rtl/rbus_arb_pkg.sv
package rbus_arb_pkg;
   typedef enum logic [1:0] {
      KIND_FP     = 2'b00,
      KIND_INT    = 2'b01,
      KIND_BRANCH = 2'b10,
      KIND_STORE  = 2'b11
   } op_kind_t;

   // Result kinds compete for the broadcast bus; branches and stores do not.
   function automatic logic kind_needs_bus(input op_kind_t k);
      return (k == KIND_FP) || (k == KIND_INT);
   endfunction
endpackage

// File: rtl/age_pick.sv
// Selects the oldest candidate by wrap-around sequence number; one-hot result.
module age_pick #(
   parameter int N  = 4,
   parameter int AW = 4
) (
   input  logic [N-1:0]    cand,
   input  logic [N*AW-1:0] age,
   output logic [N-1:0]    win
);
   function automatic logic older(input logic [AW-1:0] a, input logic [AW-1:0] b);
      logic [AW-1:0] diff;
      diff = a - b;
      return diff[AW-1];
   endfunction

   generate
      if (N == 1) begin : g_single
         assign win = cand;
      end else begin : g_multi
         always_comb begin
            for (int i = 0; i < N; i++) begin
               win[i] = cand[i];
               for (int j = 0; j < N; j++) begin
                  if (j != i && cand[j]) begin
                     if (older(age[j*AW +: AW], age[i*AW +: AW]))
                        win[i] = 1'b0;
                     else if ((age[j*AW +: AW] == age[i*AW +: AW]) && (j < i))
                        win[i] = 1'b0;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/unit_tracker.sv
// Occupancy of the non-pipelined units: set on start, cleared on release.
module unit_tracker #(
   parameter int NUNIT = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NUNIT-1:0] start,
   input  logic [NUNIT-1:0] release_u,
   output logic [NUNIT-1:0] busy
);
   always_ff @(posedge clk) begin
      if (rst)
         busy <= '0;
      else
         busy <= (busy & ~release_u) | start;
   end
endmodule

// File: rtl/wake_filter.sv
// Holds last cycle's broadcast and marks start requests whose operand is ready.
module wake_filter #(
   parameter int N     = 4,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_valid,
   input  logic [TAG_W-1:0] bus_tag,
   input  logic [N-1:0]     wait_src,
   input  logic [N*TAG_W-1:0] src_tag,
   output logic [N-1:0]     ready
);
   logic             held_v;
   logic [TAG_W-1:0] held_tag;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_v   <= 1'b0;
         held_tag <= '0;
      end else begin
         held_v   <= bus_valid;
         held_tag <= bus_tag;
      end
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_rdy
         assign ready[i] = !wait_src[i] ||
                           (held_v && (held_tag == src_tag[i*TAG_W +: TAG_W]));
      end
   endgenerate
endmodule

// File: rtl/rbus_age_arbiter.sv
module rbus_age_arbiter
   import rbus_arb_pkg::*;
#(
   parameter int NREQ   = 4,
   parameter int SEQ_W  = 4,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16,
   parameter int NUNIT  = 2,
   localparam int UIDX_W = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NREQ-1:0]         fin_valid,
   input  logic [NREQ*2-1:0]       fin_kind,
   input  logic [NREQ*SEQ_W-1:0]   fin_age,
   input  logic [NREQ*UIDX_W-1:0]  fin_unit,
   input  logic [NREQ*TAG_W-1:0]   fin_tag,
   input  logic [NREQ*DATA_W-1:0]  fin_data,
   output logic [NREQ-1:0]         fin_gnt,
   output logic [NREQ-1:0]         fin_ack,
   output logic                    bus_valid,
   output logic [TAG_W-1:0]        bus_tag,
   output logic [DATA_W-1:0]       bus_data,
   input  logic [NREQ-1:0]         ex_valid,
   input  logic [NREQ*SEQ_W-1:0]   ex_age,
   input  logic [NREQ*UIDX_W-1:0]  ex_unit,
   input  logic [NREQ-1:0]         ex_wait,
   input  logic [NREQ*TAG_W-1:0]   ex_src_tag,
   output logic [NREQ-1:0]         ex_gnt,
   output logic [NUNIT-1:0]        unit_busy
);
   generate
      if (NREQ < 1)   begin : g_bad_nreq  $error("NREQ must be at least 1");  end
      if (SEQ_W < 2)  begin : g_bad_seq   $error("SEQ_W must be at least 2"); end
      if (TAG_W < 1)  begin : g_bad_tag   $error("TAG_W must be at least 1"); end
      if (DATA_W < 1) begin : g_bad_data  $error("DATA_W must be at least 1"); end
      if (NUNIT < 1)  begin : g_bad_unit  $error("NUNIT must be at least 1"); end
   endgenerate

   logic [NREQ-1:0] res_cand;
   logic [NREQ-1:0] quiet_done;
   logic [NREQ-1:0] src_ready;
   logic [NUNIT-1:0] unit_start;
   logic [NUNIT-1:0] unit_free_evt;
   logic [NREQ-1:0] ex_win [NUNIT];

   // Classify finish requests.
   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_cls
         op_kind_t k;
         assign k             = op_kind_t'(fin_kind[i*2 +: 2]);
         assign res_cand[i]   = fin_valid[i] && !rst && kind_needs_bus(k);
         assign quiet_done[i] = fin_valid[i] && !rst && !kind_needs_bus(k);
      end
   endgenerate

   age_pick #(.N(NREQ), .AW(SEQ_W)) u_bus_pick (
      .cand (res_cand),
      .age  (fin_age),
      .win  (fin_gnt)
   );

   assign fin_ack   = fin_gnt | quiet_done;
   assign bus_valid = |fin_gnt;

   always_comb begin
      bus_tag  = '0;
      bus_data = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (fin_gnt[i]) begin
            bus_tag  = bus_tag  | fin_tag[i*TAG_W +: TAG_W];
            bus_data = bus_data | fin_data[i*DATA_W +: DATA_W];
         end
      end
   end

   // Unit release on any accepted finish.
   always_comb begin
      unit_free_evt = '0;
      for (int i = 0; i < NREQ; i++) begin
         for (int u = 0; u < NUNIT; u++) begin
            if (fin_ack[i] && (fin_unit[i*UIDX_W +: UIDX_W] == UIDX_W'(u)))
               unit_free_evt[u] = 1'b1;
         end
      end
   end

   wake_filter #(.N(NREQ), .TAG_W(TAG_W)) u_wake (
      .clk       (clk),
      .rst       (rst),
      .bus_valid (bus_valid),
      .bus_tag   (bus_tag),
      .wait_src  (ex_wait),
      .src_tag   (ex_src_tag),
      .ready     (src_ready)
   );

   // One age picker per unit.
   generate
      for (genvar u = 0; u < NUNIT; u++) begin : g_unit
         logic [NREQ-1:0] cand_u;
         for (genvar i = 0; i < NREQ; i++) begin : g_c
            assign cand_u[i] = ex_valid[i] && src_ready[i] && !rst && !unit_busy[u] &&
                               (ex_unit[i*UIDX_W +: UIDX_W] == UIDX_W'(u));
         end
         age_pick #(.N(NREQ), .AW(SEQ_W)) u_ex_pick (
            .cand (cand_u),
            .age  (ex_age),
            .win  (ex_win[u])
         );
         assign unit_start[u] = |ex_win[u];
      end
   endgenerate

   always_comb begin
      ex_gnt = '0;
      for (int u = 0; u < NUNIT; u++)
         ex_gnt = ex_gnt | ex_win[u];
   end

   unit_tracker #(.NUNIT(NUNIT)) u_units (
      .clk       (clk),
      .rst       (rst),
      .start     (unit_start),
      .release_u (unit_free_evt),
      .busy      (unit_busy)
   );
endmodule

// File: rtl/rbus_age_arbiter_chk.sv
module rbus_age_arbiter_chk #(
   parameter int NREQ   = 4,
   parameter int SEQ_W  = 4,
   parameter int TAG_W  = 6,
   parameter int NUNIT  = 2,
   parameter int UIDX_W = 1
) (
   input logic                   clk,
   input logic                   rst,
   input logic [NREQ-1:0]        fin_valid,
   input logic [NREQ*2-1:0]      fin_kind,
   input logic [NREQ*SEQ_W-1:0]  fin_age,
   input logic [NREQ*TAG_W-1:0]  fin_tag,
   input logic [NREQ-1:0]        fin_gnt,
   input logic [NREQ-1:0]        fin_ack,
   input logic                   bus_valid,
   input logic [TAG_W-1:0]       bus_tag,
   input logic [NREQ-1:0]        ex_wait,
   input logic [NREQ*UIDX_W-1:0] ex_unit,
   input logic [NREQ*TAG_W-1:0]  ex_src_tag,
   input logic [NREQ-1:0]        ex_gnt,
   input logic [NUNIT-1:0]       unit_busy
);
   assert_bus_onehot_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(fin_gnt) && (bus_valid == (fin_gnt != '0)));

   assert_reset_quiet_R8: assert property (@(posedge clk)
      rst |-> (!bus_valid && fin_gnt == '0 && fin_ack == '0 && ex_gnt == '0));

   assert_reset_free_R8: assert property (@(posedge clk)
      $past(rst) |-> (unit_busy == '0));

   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_i
         logic [SEQ_W-1:0]  age_i;
         logic [UIDX_W-1:0] unit_i;
         logic              res_i;
         assign age_i  = fin_age[i*SEQ_W +: SEQ_W];
         assign unit_i = ex_unit[i*UIDX_W +: UIDX_W];
         assign res_i  = fin_valid[i] && !fin_kind[i*2+1];

         assert_nobus_kind_R3: assert property (@(posedge clk) disable iff (rst)
            (fin_valid[i] && fin_kind[i*2+1]) |-> (!fin_gnt[i] && fin_ack[i]));

         assert_ack_is_gnt_R4: assert property (@(posedge clk) disable iff (rst)
            res_i |-> (fin_ack[i] == fin_gnt[i]));

         assert_bus_tag_R1: assert property (@(posedge clk) disable iff (rst)
            fin_gnt[i] |-> (bus_tag == fin_tag[i*TAG_W +: TAG_W]));

         assert_wake_next_cycle_R7: assert property (@(posedge clk) disable iff (rst)
            (ex_gnt[i] && ex_wait[i]) |->
               ($past(bus_valid) && $past(bus_tag) == ex_src_tag[i*TAG_W +: TAG_W]));

         for (genvar u = 0; u < NUNIT; u++) begin : g_u
            assert_start_free_R5: assert property (@(posedge clk) disable iff (rst)
               (ex_gnt[i] && unit_i == UIDX_W'(u)) |-> !unit_busy[u]);
            assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (rst)
               (ex_gnt[i] && unit_i == UIDX_W'(u)) |=> unit_busy[u]);
         end

         for (genvar j = 0; j < NREQ; j++) begin : g_j
            if (j != i) begin : g_pair
               logic [SEQ_W-1:0] diff;
               assign diff = fin_age[j*SEQ_W +: SEQ_W] - age_i;
               assert_oldest_wins_R2: assert property (@(posedge clk) disable iff (rst)
                  (fin_gnt[i] && fin_valid[j] && !fin_kind[j*2+1]) |-> !diff[SEQ_W-1]);
               assert_unit_single_R5: assert property (@(posedge clk) disable iff (rst)
                  (ex_unit[j*UIDX_W +: UIDX_W] == unit_i) |-> !(ex_gnt[i] && ex_gnt[j]));
            end
         end
      end
   endgenerate
endmodule

bind rbus_age_arbiter rbus_age_arbiter_chk #(
   .NREQ(NREQ), .SEQ_W(SEQ_W), .TAG_W(TAG_W), .NUNIT(NUNIT), .UIDX_W(UIDX_W)
) u_chk (
   .clk(clk), .rst(rst), .fin_valid(fin_valid), .fin_kind(fin_kind),
   .fin_age(fin_age), .fin_tag(fin_tag), .fin_gnt(fin_gnt), .fin_ack(fin_ack),
   .bus_valid(bus_valid), .bus_tag(bus_tag), .ex_wait(ex_wait), .ex_unit(ex_unit),
   .ex_src_tag(ex_src_tag), .ex_gnt(ex_gnt), .unit_busy(unit_busy)
);

// File: tb/tb_rbus_age_arbiter.sv
`timescale 1ns/1ps
module tb_rbus_age_arbiter;
   localparam int NREQ = 4, SEQ_W = 4, TAG_W = 6, DATA_W = 16, NUNIT = 2, UW = 1;

   logic clk = 1'b0;
   logic rst;
   logic [NREQ-1:0]        fin_valid;
   logic [NREQ*2-1:0]      fin_kind;
   logic [NREQ*SEQ_W-1:0]  fin_age;
   logic [NREQ*UW-1:0]     fin_unit;
   logic [NREQ*TAG_W-1:0]  fin_tag;
   logic [NREQ*DATA_W-1:0] fin_data;
   logic [NREQ-1:0]        fin_gnt, fin_ack;
   logic                   bus_valid;
   logic [TAG_W-1:0]       bus_tag;
   logic [DATA_W-1:0]      bus_data;
   logic [NREQ-1:0]        ex_valid, ex_wait, ex_gnt;
   logic [NREQ*SEQ_W-1:0]  ex_age;
   logic [NREQ*UW-1:0]     ex_unit;
   logic [NREQ*TAG_W-1:0]  ex_src_tag;
   logic [NUNIT-1:0]       unit_busy;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #10 clk = ~clk;

   rbus_age_arbiter #(.NREQ(NREQ), .SEQ_W(SEQ_W), .TAG_W(TAG_W),
                      .DATA_W(DATA_W), .NUNIT(NUNIT)) dut (.*);

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_all();
      fin_valid = '0; fin_kind = '0; fin_age = '0; fin_unit = '0;
      fin_tag = '0; fin_data = '0;
      ex_valid = '0; ex_age = '0; ex_unit = '0; ex_wait = '0; ex_src_tag = '0;
   endtask

   task automatic set_fin(input int i, input logic [1:0] k, input logic [3:0] a,
                          input logic u, input logic [5:0] t, input logic [15:0] d);
      fin_valid[i] = 1'b1; fin_kind[i*2 +: 2] = k; fin_age[i*SEQ_W +: SEQ_W] = a;
      fin_unit[i] = u; fin_tag[i*TAG_W +: TAG_W] = t; fin_data[i*DATA_W +: DATA_W] = d;
   endtask

   task automatic set_ex(input int i, input logic [3:0] a, input logic u,
                         input logic w, input logic [5:0] s);
      ex_valid[i] = 1'b1; ex_age[i*SEQ_W +: SEQ_W] = a; ex_unit[i] = u;
      ex_wait[i] = w; ex_src_tag[i*TAG_W +: TAG_W] = s;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      clear_all();
      rst = 1'b1;
      step(); step();
      rst = 1'b0;
      step();
   endtask

   // R8: quiet during reset, units free afterwards
   task automatic t_reset();
      clear_all();
      rst = 1'b1;
      set_fin(0, 2'b00, 4'd1, 1'b0, 6'h3, 16'h1234);
      set_ex(1, 4'd2, 1'b1, 1'b0, 6'h0);
      step(); #1;
      check("R8", "bus_valid in reset", bus_valid, 0);
      check("R8", "fin_ack in reset", fin_ack, 0);
      check("R8", "ex_gnt in reset", ex_gnt, 0);
      clear_all();
      rst = 1'b0;
      step(); #1;
      check("R8", "unit_busy after reset", unit_busy, 0);
   endtask

   // R1: single integer result
   task automatic t_single();
      do_reset();
      set_fin(2, 2'b01, 4'd3, 1'b0, 6'h11, 16'hBEEF);
      #1;
      check("R1", "grant", fin_gnt, 4'b0100);
      check("R1", "bus_valid", bus_valid, 1);
      check("R1", "bus_tag", bus_tag, 6'h11);
      check("R1", "bus_data", bus_data, 16'hBEEF);
      clear_all(); step();
   endtask

   // R2/R4: oldest first, losers keep waiting
   task automatic t_age();
      do_reset();
      set_fin(0, 2'b00, 4'd5, 1'b1, 6'h05, 16'h0005);
      set_fin(1, 2'b01, 4'd2, 1'b0, 6'h02, 16'h0002);
      set_fin(2, 2'b00, 4'd9, 1'b1, 6'h09, 16'h0009);
      #1;
      check("R2", "oldest of 5,2,9", fin_gnt, 4'b0010);
      check("R4", "ack only winner", fin_ack, 4'b0010);
      check("R1", "bus_data", bus_data, 16'h0002);
      step(); fin_valid[1] = 1'b0; #1;
      check("R2", "oldest of 5,9", fin_gnt, 4'b0001);
      step(); fin_valid[0] = 1'b0; #1;
      check("R4", "last waiter served", fin_gnt, 4'b0100);
      clear_all(); step();
   endtask

   // R2: ages wrapping past zero
   task automatic t_wrap();
      do_reset();
      set_fin(0, 2'b00, 4'd14, 1'b0, 6'h0E, 16'h000E);
      set_fin(1, 2'b00, 4'd15, 1'b0, 6'h0F, 16'h000F);
      set_fin(2, 2'b01, 4'd1,  1'b0, 6'h01, 16'h0001);
      #1;
      check("R2", "wrap 14,15,1", fin_gnt, 4'b0001);
      step(); fin_valid[0] = 1'b0; #1;
      check("R2", "wrap 15,1", fin_gnt, 4'b0010);
      check("R1", "bus_tag wrap", bus_tag, 6'h0F);
      clear_all(); step();
   endtask

   // R3: branch/store bypass the bus
   task automatic t_nobus();
      do_reset();
      set_fin(0, 2'b10, 4'd1, 1'b0, 6'h21, 16'h1111);
      set_fin(1, 2'b11, 4'd2, 1'b1, 6'h22, 16'h2222);
      set_fin(2, 2'b00, 4'd7, 1'b1, 6'h27, 16'h7777);
      #1;
      check("R3", "result granted over older branch/store", fin_gnt, 4'b0100);
      check("R3", "branch/store acked", fin_ack, 4'b0111);
      check("R3", "bus_tag", bus_tag, 6'h27);
      step(); fin_valid[2] = 1'b0; #1;
      check("R3", "branch/store alone no bus", bus_valid, 0);
      check("R3", "no grant", fin_gnt, 0);
      clear_all(); step();
   endtask

   // R5/R6: unit contention and one-cycle handoff
   task automatic t_unit();
      do_reset();
      set_ex(0, 4'd4, 1'b1, 1'b0, 6'h0);
      set_ex(1, 4'd2, 1'b1, 1'b0, 6'h0);
      set_ex(2, 4'd6, 1'b0, 1'b0, 6'h0);
      #1;
      check("R5", "oldest per unit, both units", ex_gnt, 4'b0110);
      step();
      ex_valid[1] = 1'b0; ex_valid[2] = 1'b0;
      set_fin(1, 2'b01, 4'd2, 1'b1, 6'h12, 16'h0012);
      #1;
      check("R6", "both busy", unit_busy, 2'b11);
      check("R5", "no start on busy unit in finish cycle", ex_gnt, 0);
      check("R4", "occupant finish granted", fin_gnt, 4'b0010);
      step(); fin_valid[1] = 1'b0; #1;
      check("R6", "unit1 freed next cycle", unit_busy, 2'b01);
      check("R6", "stalled start granted", ex_gnt, 4'b0001);
      step();
      ex_valid[0] = 1'b0;
      set_fin(3, 2'b10, 4'd6, 1'b0, 6'h00, 16'h0);
      #1;
      check("R3", "branch on unit0 acked", fin_ack, 4'b1000);
      step(); clear_all(); #1;
      check("R6", "unit0 freed by branch", unit_busy, 2'b10);
      step();
   endtask

   // R7: tag wakeup only the cycle after broadcast
   task automatic t_wake();
      do_reset();
      set_ex(0, 4'd1, 1'b0, 1'b1, 6'h2A);
      set_fin(1, 2'b00, 4'd3, 1'b1, 6'h15, 16'h0015);
      #1;
      check("R7", "no start before tag", ex_gnt, 0);
      step();
      fin_tag[1*TAG_W +: TAG_W] = 6'h2A;
      #1;
      check("R7", "tag on bus", bus_tag, 6'h2A);
      check("R7", "no start in broadcast cycle", ex_gnt, 0);
      step(); fin_valid[1] = 1'b0; #1;
      check("R7", "start cycle after broadcast", ex_gnt, 4'b0001);
      clear_all(); step();
   endtask

   initial begin
      clear_all();
      rst = 1'b1;
      step();
      t_reset();
      t_single();
      t_age();
      t_wrap();
      t_nobus();
      t_unit();
      t_wake();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule